// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Block

This block is a 32-pin general-purpose I/O port behind a plain 32-bit memory-mapped register bus. The bus has an address, a write strobe, write data and combinational read data. Each pin has a direction bit and an output latch. The pad output enable follows the direction bit, and the pad data follows the latch.

Direction never needs a read-modify-write. One offset turns pins into outputs, and a second offset turns pins back into inputs. In both cases only the pins whose bits are written as 1 are affected. Output levels are written through two half-width registers, one for the low sixteen pins and one for the high sixteen. Each of these registers carries a per-pin write mask in its upper half, so a single pin can be changed in one bus write.

A latch can be loaded while its pin is still an input. The pin then drives the intended level on the very cycle it becomes an output. Pad levels pass through a two-flop synchronizer. The synchronized vector is readable over the bus, and it is also exported on its own port for an interrupt-detection block.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is asserted and right after it, every pin is an input (pad_oe all 0) and every output latch is 0 (pad_out all 0).
- R2: A write to offset 0x00 sets direction bit n to 1 (output) for every write-data bit n that is 1. Pins whose bit is 0 keep their direction.
- R3: A write to offset 0x04 clears direction bit n to 0 (input) for every write-data bit n that is 1. Pins whose bit is 0 keep their direction.
- R4: A write to offset 0x08 updates the latches of pins 0 to 15. Write-data bit 16+k enables pin k, and bit k is its new level. Pins that are not enabled, and pins 16 to 31, are unchanged.
- R5: A write to offset 0x0C updates the latches of pins 16 to 31. Write-data bit 16+k enables pin 16+k, and bit k is its new level. Pins that are not enabled, and pins 0 to 15, are unchanged.
- R6: A read of offset 0x10, and the pin_level port, return the pad levels through two flops. A change on pin_in that is set up before rising edge E is not visible after E. It becomes visible after edge E+1.
- R7: Reads return the following values.
  - Offset 0x04 returns the direction vector, with 1 meaning output.
  - Offsets 0x08 and 0x0C return the low or the high sixteen latches in bits [15:0], with bits [31:16] read as 0.
  - Every other offset, including 0x00, reads as 0.
- R8: pad_oe equals the direction vector and pad_out equals the latches at all times. A latch written while its pin is an input drives its level on the first cycle the pin becomes an output.
- R9: A cycle with bus_we low, or a write to any offset other than 0x00, 0x04, 0x08 or 0x0C, changes neither direction nor latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pin_in | input | DATA_W | Raw pad levels, asynchronous |
| pin_level | output | DATA_W | Synchronized pad levels, for interrupt detection |
| pad_oe | output | DATA_W | Pad output enable, 1 = drive |
| pad_out | output | DATA_W | Pad output data |

## Verification
The bench builds the block with its default parameters: DATA_W of 32, ADDR_W of 8 and SYNC_STAGES of 2. With these values the two output halves are separate registers, so the masked writes can be shown to leave the opposite half alone. They also give the synchronizer a fixed two-edge latency, which the bench measures edge by edge. The 8-bit address space leaves unmapped offsets such as 0x14 available to show that stray writes are dropped.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam logic [7:0] OFS_DIR_SET = 8'h00;
    localparam logic [7:0] OFS_DIR_CLR = 8'h04;
    localparam logic [7:0] OFS_OUT_LO  = 8'h08;
    localparam logic [7:0] OFS_OUT_HI  = 8'h0C;
    localparam logic [7:0] OFS_PIN     = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR_SET,
        SEL_DIR_CLR,
        SEL_OUT_LO,
        SEL_OUT_HI,
        SEL_PIN
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] dir
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir <= '0;
        else if (set_en) dir <= dir | bits;
        else if (clr_en) dir <= dir & ~bits;
    end
endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [HW-1:0] mask,
    input  logic [HW-1:0] val,
    output logic [HW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= (q & ~mask) | (val & mask);
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_level,
    output logic [DATA_W-1:0] pad_oe,
    output logic [DATA_W-1:0] pad_out
);
    localparam int HALF_W = DATA_W / 2;

    reg_sel_e          sel;
    logic [DATA_W-1:0] dir;
    logic [HALF_W-1:0] out_q [2];

    // Address decode
    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_DIR_SET)) sel = SEL_DIR_SET;
        else if (bus_addr == ADDR_W'(OFS_DIR_CLR)) sel = SEL_DIR_CLR;
        else if (bus_addr == ADDR_W'(OFS_OUT_LO))  sel = SEL_OUT_LO;
        else if (bus_addr == ADDR_W'(OFS_OUT_HI))  sel = SEL_OUT_HI;
        else if (bus_addr == ADDR_W'(OFS_PIN))     sel = SEL_PIN;
        else                                       sel = SEL_NONE;
    end

    gpio_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_level)
    );

    gpio_dir_reg #(.W(DATA_W)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_we && sel == SEL_DIR_SET),
        .clr_en (bus_we && sel == SEL_DIR_CLR),
        .bits   (bus_wdata),
        .dir    (dir)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        gpio_out_half #(.HW(HALF_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_we && sel == ((h == 0) ? SEL_OUT_LO : SEL_OUT_HI)),
            .mask  (bus_wdata[DATA_W-1:HALF_W]),
            .val   (bus_wdata[HALF_W-1:0]),
            .q     (out_q[h])
        );
    end

    assign pad_oe  = dir;
    assign pad_out = {out_q[1], out_q[0]};

    // Read mux
    always_comb begin
        unique case (sel)
            SEL_DIR_CLR: bus_rdata = dir;
            SEL_OUT_LO:  bus_rdata = {{(DATA_W-HALF_W){1'b0}}, out_q[0]};
            SEL_OUT_HI:  bus_rdata = {{(DATA_W-HALF_W){1'b0}}, out_q[1]};
            SEL_PIN:     bus_rdata = pin_level;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pad_oe,
    input logic [DATA_W-1:0] pad_out
);
    localparam int HALF_W = DATA_W / 2;

    logic wr_set, wr_clr, wr_lo, wr_hi;
    logic [HALF_W-1:0] msk, val;
    assign wr_set = bus_we && bus_addr == ADDR_W'(OFS_DIR_SET);
    assign wr_clr = bus_we && bus_addr == ADDR_W'(OFS_DIR_CLR);
    assign wr_lo  = bus_we && bus_addr == ADDR_W'(OFS_OUT_LO);
    assign wr_hi  = bus_we && bus_addr == ADDR_W'(OFS_OUT_HI);
    assign msk    = bus_wdata[DATA_W-1:HALF_W];
    assign val    = bus_wdata[HALF_W-1:0];

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (pad_oe == '0 && pad_out == '0);
        end
    end

    a_r2_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> pad_oe == ($past(pad_oe) | $past(bus_wdata)));

    a_r3_dir_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> pad_oe == ($past(pad_oe) & ~$past(bus_wdata)));

    a_r4_out_lo: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> pad_out[HALF_W-1:0] ==
            (($past(pad_out[HALF_W-1:0]) & ~$past(msk)) | ($past(val) & $past(msk)))
            && $stable(pad_out[DATA_W-1:HALF_W]));

    a_r5_out_hi: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> pad_out[DATA_W-1:HALF_W] ==
            (($past(pad_out[DATA_W-1:HALF_W]) & ~$past(msk)) | ($past(val) & $past(msk)))
            && $stable(pad_out[HALF_W-1:0]));

    a_r7_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(OFS_DIR_CLR) |-> bus_rdata == pad_oe);

    a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pad_oe));

    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo || wr_hi) |=> $stable(pad_out));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_level;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_port_regs u_gpio_port_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_level (pin_level),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 pad_oe in reset", pad_oe, 32'h0);
        chk("R1 pad_out in reset", pad_out, 32'h0);
        rst_n = 1'b1;
        rd_chk("R1 dir after reset", 8'h04, 32'h0);
        rd_chk("R1 out lo after reset", 8'h08, 32'h0);
        rd_chk("R1 out hi after reset", 8'h0C, 32'h0);
    endtask

    task automatic t_dir;
        wr(8'h00, 32'h0000_00F1);
        chk("R2 set F1", pad_oe, 32'h0000_00F1);
        wr(8'h00, 32'h0000_0100);
        chk("R2 zeros keep", pad_oe, 32'h0000_01F1);
        wr(8'h04, 32'h0000_0011);
        chk("R3 clear 11", pad_oe, 32'h0000_01E0);
        rd_chk("R7 dir readback", 8'h04, 32'h0000_01E0);
        rd_chk("R7 offset 0 reads 0", 8'h00, 32'h0);
    endtask

    task automatic t_out_lo;
        wr(8'h08, 32'hFFFF_A5A5);
        chk("R4 full mask", pad_out, 32'h0000_A5A5);
        wr(8'h08, 32'h000F_0000);
        chk("R4 nibble clear", pad_out, 32'h0000_A5A0);
        wr(8'h08, 32'h0000_FFFF);
        chk("R4 zero mask", pad_out, 32'h0000_A5A0);
        rd_chk("R7 out lo readback", 8'h08, 32'h0000_A5A0);
    endtask

    task automatic t_out_hi;
        wr(8'h0C, 32'h8001_FFFF);
        chk("R5 pins 16 and 31", pad_out, 32'h8001_A5A0);
        rd_chk("R7 out hi readback", 8'h0C, 32'h0000_8001);
    endtask

    task automatic t_preload;
        wr(8'h0C, 32'h0010_0010);
        chk("R8 latch while input", pad_out, 32'h8011_A5A0);
        chk("R8 pin 20 still input", pad_oe, 32'h0000_01E0);
        wr(8'h00, 32'h0010_0000);
        chk("R8 oe follows dir", pad_oe, 32'h0010_01E0);
        chk("R8 preloaded level driven", pad_out & pad_oe, 32'h0010_01A0);
    endtask

    task automatic t_sync(input logic [31:0] v, input logic [31:0] prev);
        @(negedge clk);
        pin_in = v; bus_addr = 8'h10;
        @(posedge clk); #1;
        chk("R6 not after first edge", bus_rdata, prev);
        chk("R6 port not after first edge", pin_level, prev);
        @(posedge clk); #1;
        chk("R6 after second edge", bus_rdata, v);
        chk("R6 port after second edge", pin_level, v);
    endtask

    task automatic t_ignore;
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
        @(negedge clk);
        chk("R9 no we dir", pad_oe, 32'h0010_01E0);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        chk("R9 stray write dir", pad_oe, 32'h0010_01E0);
        chk("R9 stray write out", pad_out, 32'h8011_A5A0);
        rd_chk("R7 unmapped reads 0", 8'h14, 32'h0);
    endtask

    initial begin
        t_reset;
        t_dir;
        t_out_lo;
        t_out_hi;
        t_preload;
        t_sync(32'hDEAD_BEEF, 32'h0);
        t_sync(32'h1234_5678, 32'hDEAD_BEEF);
        t_ignore;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule